// File: doc/BRIEF.md
# Sanitising Table-Base Register Pair

This block keeps two 64-bit configuration words that tell an interrupt translation engine where its in-memory tables sit. The first word is a property-table base shared by all cores; the second is the pending-table base for one core. Software reaches both over a simple register bus. Every request is accepted in the cycle it is presented, and a read answers on the following cycle. Each word can be accessed as a whole 64-bit quantity or as either of its 32-bit halves.

A write is first merged into the stored word. Reserved bits are then cleared. The cacheability and shareability fields are forced to encodings the system supports, and the result is stored in a single clock edge. While the external enable input `lpi_en` is high, the table bases are frozen and every write is dropped. The stored words are driven out continuously on `prop_base` and `pend_base` for the table-walking logic downstream.

Top module: `tbase_regpair`

## Requirements
- R1: Both words reset to zero. The property base lives at byte offset 0x0 and the pending base at 0x8, so address bit 3 selects the word. A 64-bit access has `req_size`=3 and low address bits 000; a write of that kind replaces the whole word before sanitising.
- R2: A 32-bit access has `req_size`=2 and address bits [1:0]=00. On a 32-bit write, the data is taken from `req_wdata[31:0]`. Address bit 2 picks the half to replace (1 = upper), and the other half keeps its value.
- R3: A read request gives `rsp_valid`=1 on the next cycle. A 64-bit read returns the whole word. A 32-bit read returns the half chosen by address bit 2 in bits [31:0], with zeros above. `rsp_valid` is 0 in any cycle that follows a cycle without a read request.
- R4: While `lpi_en` is 1, a write to either word leaves both words unchanged.
- R5: After any write, the property base has every bit of the mask 0xF8F0_0000_0000_0060 at zero.
- R6: After any write, the pending base has every bit of the mask 0xB8F0_0000_0000_F07F at zero.
- R7: Inner cacheability sits at bits [9:7]. After a write, code 000 or 001 is stored as 101, and every other code is kept.
- R8: Outer cacheability sits at bits [58:56]. Codes 000 and 001 are kept, and every other code is stored as 000.
- R9: Shareability sits at bits [11:10]. Code 10 is stored as 01, and the codes 00, 01 and 11 are kept.
- R10: An access with `req_size` 0 or 1, a 64-bit access with nonzero address bits [2:0], or a 32-bit access with nonzero address bits [1:0] changes no word on a write and returns zero on a read.
- R11: The sanitised result of a write is visible on `prop_base`/`pend_base` right after the clock edge that accepts it, and a read in the next cycle returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpi_en | input | 1 | Table-engine enable; locks both words while high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address inside the block |
| req_size | input | 2 | log2 of access bytes (2 = 32-bit, 3 = 64-bit) |
| req_wdata | input | 64 | Write data (32-bit writes use bits [31:0]) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 64 | Read data |
| prop_base | output | 64 | Stored property-table base |
| pend_base | output | 64 | Stored pending-table base |

## Verification
A write lands on `prop_base`/`pend_base` at the same rising edge that samples the request. A read result appears on `rsp_valid`/`rsp_data` at that edge as well, which is one cycle after the request was presented. The bench drives each request on a falling edge, lets exactly one rising edge pass, and compares all outputs on the next falling edge against its own model. Every result is therefore judged in the one cycle where it is due. Locked, malformed and attribute-corner writes are interleaved with seeded random traffic so that each sanitising rule meets both its legal and its coerced codes.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   // access size, encoded as log2 of the byte count
   typedef enum logic [1:0] {
      SZ_B1  = 2'd0,
      SZ_B2  = 2'd1,
      SZ_W32 = 2'd2,
      SZ_W64 = 2'd3
   } acc_size_e;
endpackage

// File: rtl/tbase_merge.sv
module tbase_merge #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] old_q,
   input  logic [DATA_W-1:0] wdata,
   input  logic              full,
   input  logic              upper,
   output logic [DATA_W-1:0] merged
);
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("tbase_merge: DATA_W must be even");
   end

   always_comb begin
      merged = old_q;
      if (full)
         merged = wdata;
      else if (upper)
         merged[DATA_W-1:HALF_W] = wdata[HALF_W-1:0];
      else
         merged[HALF_W-1:0] = wdata[HALF_W-1:0];
   end
endmodule

// File: rtl/tbase_sanitise.sv
module tbase_sanitise #(
   parameter int                DATA_W    = 64,
   parameter logic [DATA_W-1:0] RSVD_MASK = '0,
   parameter bit                LEGALISE  = 1'b1,
   parameter int                ATTR_W    = 3,
   parameter int                SHARE_W   = 2,
   parameter int                INNER_LSB = 7,
   parameter int                OUTER_LSB = 56,
   parameter int                SHARE_LSB = 10,
   parameter logic [2:0]        CACHE_FILL = 3'b101
) (
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] clean
);
   localparam logic [ATTR_W-1:0]  C_DEVICE = ATTR_W'(0);
   localparam logic [ATTR_W-1:0]  C_NONC   = ATTR_W'(1);
   localparam logic [ATTR_W-1:0]  C_FILL   = ATTR_W'(CACHE_FILL);
   localparam logic [SHARE_W-1:0] S_OUTER  = SHARE_W'(2);
   localparam logic [SHARE_W-1:0] S_INNER  = SHARE_W'(1);

   if (INNER_LSB + ATTR_W > DATA_W || OUTER_LSB + ATTR_W > DATA_W ||
       SHARE_LSB + SHARE_W > DATA_W) begin : g_bad_field
      $error("tbase_sanitise: attribute field outside the word");
   end

   logic [DATA_W-1:0] masked;
   assign masked = raw & ~RSVD_MASK;

   if (LEGALISE) begin : g_legal
      logic [ATTR_W-1:0]  inner_c;
      logic [ATTR_W-1:0]  outer_c;
      logic [SHARE_W-1:0] share_c;

      always_comb begin
         inner_c = masked[INNER_LSB +: ATTR_W];
         outer_c = masked[OUTER_LSB +: ATTR_W];
         share_c = masked[SHARE_LSB +: SHARE_W];
         clean   = masked;
         // device or non-cacheable inner: promote to write-back
         if (inner_c == C_DEVICE || inner_c == C_NONC)
            clean[INNER_LSB +: ATTR_W] = C_FILL;
         // outer: only "as inner" or non-cacheable survive
         if (outer_c != C_DEVICE && outer_c != C_NONC)
            clean[OUTER_LSB +: ATTR_W] = C_DEVICE;
         if (share_c == S_OUTER)
            clean[SHARE_LSB +: SHARE_W] = S_INNER;
      end
   end else begin : g_mask_only
      assign clean = masked;
   end
endmodule

// File: rtl/tbase_slot.sv
module tbase_slot #(
   parameter int                DATA_W    = 64,
   parameter logic [DATA_W-1:0] RSVD_MASK = '0,
   parameter bit                LEGALISE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              full,
   input  logic              upper,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] clean;

   tbase_merge #(.DATA_W(DATA_W)) u_merge (
      .old_q  (q),
      .wdata  (wdata),
      .full   (full),
      .upper  (upper),
      .merged (merged)
   );

   tbase_sanitise #(
      .DATA_W    (DATA_W),
      .RSVD_MASK (RSVD_MASK),
      .LEGALISE  (LEGALISE)
   ) u_sanitise (
      .raw   (merged),
      .clean (clean)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= clean;
   end
endmodule

// File: rtl/tbase_regpair.sv
module tbase_regpair
   import tbase_pkg::*;
#(
   parameter int                DATA_W    = 64,
   parameter int                ADDR_W    = 4,
   parameter logic [DATA_W-1:0] PROP_RSVD = 64'hF8F0_0000_0000_0060,
   parameter logic [DATA_W-1:0] PEND_RSVD = 64'hB8F0_0000_0000_F07F,
   parameter bit                LEGALISE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lpi_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [DATA_W-1:0] prop_base,
   output logic [DATA_W-1:0] pend_base
);
   localparam int NUM_REGS = 2;
   localparam int OFF_W    = $clog2(DATA_W / 8);
   localparam int HALF_W   = DATA_W / 2;

   if (ADDR_W != OFF_W + 1) begin : g_bad_addr
      $error("tbase_regpair: ADDR_W must cover exactly two words");
   end
   if (DATA_W != 64) begin : g_bad_data
      $error("tbase_regpair: word must be 64 bits for 32-bit halves");
   end

   logic [OFF_W-1:0]  off;
   logic              reg_sel;
   logic              is_full;
   logic              is_half;
   logic              wr_go;
   logic              rd_go;
   logic [DATA_W-1:0] regs_q [NUM_REGS];
   logic [DATA_W-1:0] src;
   logic [DATA_W-1:0] rd_val;

   assign off     = req_addr[OFF_W-1:0];
   assign reg_sel = req_addr[OFF_W];
   assign is_full = (acc_size_e'(req_size) == SZ_W64) && (off == '0);
   assign is_half = (acc_size_e'(req_size) == SZ_W32) && (off[OFF_W-2:0] == '0);
   assign wr_go   = req_valid && req_write && (is_full || is_half) && !lpi_en;
   assign rd_go   = req_valid && !req_write;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      localparam logic [DATA_W-1:0] MASK = (g == 0) ? PROP_RSVD : PEND_RSVD;
      tbase_slot #(
         .DATA_W    (DATA_W),
         .RSVD_MASK (MASK),
         .LEGALISE  (LEGALISE)
      ) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr_go && (reg_sel == 1'(g))),
         .full  (is_full),
         .upper (off[OFF_W-1]),
         .wdata (req_wdata),
         .q     (regs_q[g])
      );
   end

   always_comb begin
      src    = regs_q[reg_sel];
      rd_val = '0;
      if (is_full)
         rd_val = src;
      else if (is_half)
         rd_val = {{HALF_W{1'b0}},
                   off[OFF_W-1] ? src[DATA_W-1:HALF_W] : src[HALF_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_go;
         if (rd_go)
            rsp_data <= rd_val;
      end
   end

   assign prop_base = regs_q[0];
   assign pend_base = regs_q[1];
endmodule

// File: rtl/tbase_regpair_chk.sv
module tbase_regpair_chk #(
   parameter int                DATA_W    = 64,
   parameter int                ADDR_W    = 4,
   parameter logic [DATA_W-1:0] PROP_RSVD = 64'hF8F0_0000_0000_0060,
   parameter logic [DATA_W-1:0] PEND_RSVD = 64'hB8F0_0000_0000_F07F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lpi_en,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic [DATA_W-1:0] prop_base,
   input logic [DATA_W-1:0] pend_base
);
   localparam int OFF_W = ADDR_W - 1;

   logic rd_req, wr_req, bad_acc, good_wr;
   assign rd_req  = req_valid && !req_write;
   assign wr_req  = req_valid && req_write;
   assign bad_acc = !((req_size == 2'd3 && req_addr[OFF_W-1:0] == '0) ||
                      (req_size == 2'd2 && req_addr[OFF_W-2:0] == '0));
   assign good_wr = wr_req && !bad_acc && !lpi_en;

   p_rsp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);
   p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid);
   p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lpi_en |=> ($stable(prop_base) && $stable(pend_base)));
   p_prop_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_base & PROP_RSVD) == '0);
   p_pend_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_base & PEND_RSVD) == '0);
   p_inner_prop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && !req_addr[OFF_W]) |=> (prop_base[9:7] > 3'd1));
   p_inner_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (good_wr && req_addr[OFF_W]) |=> (pend_base[9:7] > 3'd1));
   p_outer_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_base[58:56] <= 3'd1) && (pend_base[58:56] <= 3'd1));
   p_share_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prop_base[11:10] != 2'b10) && (pend_base[11:10] != 2'b10));
   p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && bad_acc) |=> (rsp_data == '0));
   p_bad_write_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && bad_acc) |=> ($stable(prop_base) && $stable(pend_base)));
endmodule

bind tbase_regpair tbase_regpair_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .PROP_RSVD (PROP_RSVD),
   .PEND_RSVD (PEND_RSVD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lpi_en    (lpi_en),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_size  (req_size),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data),
   .prop_base (prop_base),
   .pend_base (pend_base)
);

// File: tb/tbase_regpair_test.sv
`timescale 1ns/1ps
module tbase_regpair_test;
   localparam logic [63:0] PROP_M = 64'hF8F0_0000_0000_0060;
   localparam logic [63:0] PEND_M = 64'hB8F0_0000_0000_F07F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lpi_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic [63:0] prop_base;
   logic [63:0] pend_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [63:0] m_prop = '0;
   logic [63:0] m_pend = '0;

   always #4 clk = ~clk;

   tbase_regpair uut (
      .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .prop_base(prop_base), .pend_base(pend_base)
   );

   function automatic logic [63:0] legalise(logic [63:0] v, logic [63:0] rsvd);
      logic [63:0] r;
      r = v & ~rsvd;
      if (r[9:7] == 3'b000 || r[9:7] == 3'b001) r[9:7] = 3'b101;
      if (r[58:56] > 3'b001) r[58:56] = 3'b000;
      if (r[11:10] == 2'b10) r[11:10] = 2'b01;
      return r;
   endfunction

   function automatic bit access_ok(logic [3:0] a, logic [1:0] sz);
      return (sz == 2'd3 && a[2:0] == 3'd0) || (sz == 2'd2 && a[1:0] == 2'd0);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; leaves at the next falling edge after checking
   task automatic op(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                     input logic [63:0] d, input bit lock, input string req);
      logic [63:0] cur, nxt, exp_rd;
      bit ok;
      ok  = access_ok(a, sz);
      cur = a[3] ? m_pend : m_prop;
      exp_rd = '0;
      if (ok) begin
         if (sz == 2'd3) exp_rd = cur;
         else exp_rd = a[2] ? {32'h0, cur[63:32]} : {32'h0, cur[31:0]};
      end
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
      req_wdata = d; lpi_en = lock;
      @(negedge clk);
      if (wr && ok && !lock) begin
         nxt = cur;
         if (sz == 2'd3) nxt = d;
         else if (a[2]) nxt[63:32] = d[31:0];
         else nxt[31:0] = d[31:0];
         if (a[3]) m_pend = legalise(nxt, PEND_M);
         else      m_prop = legalise(nxt, PROP_M);
      end
      if (!wr) begin
         check(req, {63'h0, rsp_valid}, 64'h1);
         check(req, rsp_data, exp_rd);
      end else begin
         check(req, {63'h0, rsp_valid}, 64'h0);
      end
      check(req, prop_base, m_prop);
      check(req, pend_base, m_pend);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", prop_base, 64'h0);
      check("R1", pend_base, 64'h0);
      check("R3", {63'h0, rsp_valid}, 64'h0);

      // R1 full writes, all ones and a plain pattern
      op(1, 4'h0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R1");
      op(1, 4'h8, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6");
      op(0, 4'h0, 2'd3, 64'h0, 0, "R5");
      op(0, 4'h8, 2'd3, 64'h0, 0, "R6");
      // R2 half writes
      op(1, 4'h8, 2'd3, 64'h0123_4567_89AB_CD80, 0, "R2");
      op(1, 4'hC, 2'd2, 64'hDEAD_BEEF_0055_AA00, 0, "R2");
      op(1, 4'h8, 2'd2, 64'h1111_1111_1234_5B80, 0, "R2");
      // R3 half reads
      op(0, 4'hC, 2'd2, 64'h0, 0, "R3");
      op(0, 4'h8, 2'd2, 64'h0, 0, "R3");
      op(0, 4'h4, 2'd2, 64'h0, 0, "R3");
      // R7 inner codes 000 and 001 promoted, 110 kept
      op(1, 4'h0, 2'd3, 64'h0000_0000_1000_0000, 0, "R7");
      op(1, 4'h0, 2'd3, 64'h0000_0000_1000_0080, 0, "R7");
      op(1, 4'h8, 2'd3, 64'h0000_0000_2000_0300, 0, "R7");
      // R8 outer codes
      op(1, 4'h0, 2'd3, 64'h0200_0000_0000_0300, 0, "R8");
      op(1, 4'h0, 2'd3, 64'h0100_0000_0000_0300, 0, "R8");
      op(1, 4'hC, 2'd2, 64'h0000_0000_0700_0000, 0, "R8");
      // R9 shareability codes
      op(1, 4'h0, 2'd3, 64'h0000_0000_0000_0B80, 0, "R9");
      op(1, 4'h8, 2'd3, 64'h0000_0000_0000_0F80, 0, "R9");
      // R4 lock
      op(1, 4'h0, 2'd3, 64'h0000_1234_5678_0000, 1, "R4");
      op(1, 4'hC, 2'd2, 64'h0000_0000_FFFF_FFFF, 1, "R4");
      op(0, 4'h0, 2'd3, 64'h0, 1, "R4");
      // R10 malformed accesses
      op(1, 4'h0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10");
      op(1, 4'h8, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10");
      op(1, 4'h4, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10");
      op(1, 4'hA, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10");
      op(0, 4'hC, 2'd3, 64'h0, 0, "R10");
      op(0, 4'h2, 2'd2, 64'h0, 0, "R10");
      op(0, 4'h0, 2'd1, 64'h0, 0, "R10");
      // R11 write then immediate read-back
      op(1, 4'h8, 2'd3, 64'hFEDC_BA98_7654_3210, 0, "R11");
      op(0, 4'h8, 2'd3, 64'h0, 0, "R11");

      // seeded random traffic
      for (int i = 0; i < 600; i++) begin
         logic [1:0] sz;
         logic [3:0] a;
         int pick;
         pick = $urandom_range(0, 9);
         sz = (pick < 4) ? 2'd3 : (pick < 8) ? 2'd2 : 2'($urandom_range(0, 1));
         a  = 4'($urandom_range(0, 15));
         if (pick < 7) a[1:0] = 2'b00;
         if (pick < 3) a[2] = 1'b0;
         op(bit'($urandom_range(0, 1)), a, sz, {$urandom, $urandom},
            ($urandom_range(0, 4) == 0), "R11");
      end

      req_valid = 1'b0;
      lpi_en    = 1'b0;
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R11: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule